// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a segment value and an offset into a linear address. It works in one of two modes, and each request chooses its own mode. In real mode the 16-bit segment value is scaled by sixteen and the low 16 bits of the offset are added to it, which gives a 20-bit address. In protected mode the segment input is treated as a selector. The caller also supplies the descriptor that the selector refers to. The block adds the descriptor base to the offset and tests the offset against the limit, scaled by granularity. It also tests the present bit and the privilege rule.

Requests arrive on a valid/ready handshake. Each result is held in a single output register that is also handled by valid/ready. A small state machine controls that register. It has two states, `ST_EMPTY` and `ST_FULL`, and three transitions:

- `load`: an accepted request moves the machine from empty to full.
- `drain`: a consumed result with no new request behind it moves the machine from full back to empty.
- `stall`: an unconsumed result keeps the machine in full and blocks new requests. A consumed result that has a request waiting behind it is replaced in the same cycle, and the machine also stays in full.

Top module: `seg_xlate_top`

## Requirements
- R1: When `req_prot`=0, `rsp_addr` is `{seg,4'b0} + off[15:0]` taken modulo 2^20, with bits 31:20 equal to zero. `rsp_fault` is 0. Offset bits 31:16 and all descriptor inputs have no effect.
- R2: In protected mode with `desc_big`=1 and no fault, `rsp_addr` is `desc_base + req_off` taken modulo 2^32.
- R3: In protected mode with `desc_big`=0, only `req_off[15:0]` is used, both for the address sum and for the limit test.
- R4: When `desc_gran`=0, the effective limit is the 20-bit limit counted in bytes. An offset equal to the limit is allowed. An offset one above the limit gives fault code 3.
- R5: When `desc_gran`=1, the effective limit is `{limit, 12'hFFF}`.
- R6: When `desc_present`=0, the fault code is 1. This code has priority over every other fault.
- R7: When max(`req_seg[1:0]`, `req_cpl`) > `desc_dpl`, the fault code is 2. This code has priority over the limit fault.
- R8: A response with a nonzero fault code carries `rsp_addr` = 0.
- R9: The result appears on the clock edge that follows acceptance. If `rsp_ready` is low, `rsp_valid` and the response fields stay unchanged.
- R10: `req_ready` is high when the output register is empty or when `rsp_ready` is high. Otherwise it is low.
- R11: While reset is applied, and right after it ends, `rsp_valid` is 0 and `req_ready` is 1.
- R12: In protected mode, `rsp_index` = `req_seg[15:3]` and `rsp_global` = `req_seg[2]`. A global value of 1 selects the global table. Both outputs are zero in real mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_prot | input | 1 | 0 = real mode, 1 = protected mode |
| req_seg | input | 16 | Segment value (real mode) or selector (protected mode) |
| req_off | input | 32 | Offset |
| req_cpl | input | 2 | Current privilege level |
| desc_base | input | 32 | Descriptor base |
| desc_limit | input | 20 | Descriptor limit |
| desc_gran | input | 1 | Limit granularity: 0 = bytes, 1 = 4 KB units |
| desc_present | input | 1 | Segment present |
| desc_big | input | 1 | Default size: 0 = 16-bit, 1 = 32-bit |
| desc_dpl | input | 2 | Descriptor privilege level |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed this cycle |
| rsp_addr | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 privilege, 3 limit |
| rsp_index | output | 13 | Selector index echo |
| rsp_global | output | 1 | Selector table bit echo |

## Verification
Every result, including its fault code and selector echo, becomes visible one cycle after the rising edge that accepted the request. The bench applies a request at a falling edge, waits for the next rising edge, and samples at the falling edge that follows. `req_ready` is combinational from the state and `rsp_ready`, so it is checked at a falling edge in the same cycle that `rsp_ready` changes. During a stall the bench samples over several falling edges to confirm that the held result does not move. It then checks that a waiting request is taken on the same edge that drains the old result.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PRIV   = 2'd2,
        FLT_LIMIT  = 2'd3
    } fault_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ostate_e;

endpackage

// File: rtl/seg_real_path.sv
module seg_real_path #(
    parameter int SEG_W  = 16,
    parameter int REAL_W = 20,
    parameter int OFF_W  = 32
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [OFF_W-1:0] addr
);
    localparam int REAL_SH = REAL_W - SEG_W;

    logic [REAL_W-1:0] seg_scaled;
    logic [REAL_W-1:0] off_ext;
    logic [REAL_W-1:0] sum;

    always_comb begin
        seg_scaled = {seg, {REAL_SH{1'b0}}};
        off_ext    = REAL_W'(off[SEG_W-1:0]);
        sum        = seg_scaled + off_ext;
        addr       = OFF_W'(sum);
    end
endmodule

// File: rtl/seg_prot_path.sv
module seg_prot_path
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    parameter int PL_W    = 2
) (
    input  logic [SEG_W-1:0]        sel,
    input  logic [OFF_W-1:0]        off,
    input  logic [PL_W-1:0]         cpl,
    input  logic [OFF_W-1:0]        base,
    input  logic [LIM_W-1:0]        limit,
    input  logic                    gran,
    input  logic                    present,
    input  logic                    big,
    input  logic [PL_W-1:0]         dpl,
    output logic [OFF_W-1:0]        addr,
    output fault_e                  fault,
    output logic [SEG_W-PL_W-2:0]   idx,
    output logic                    glb
);
    localparam int HALF_W = OFF_W / 2;
    localparam logic [OFF_W-1:0] GRAN_MASK = (OFF_W'(1) << GRAN_SH) - OFF_W'(1);

    logic [OFF_W-1:0] eff_off;
    logic [OFF_W-1:0] lim_ext;
    logic [OFF_W-1:0] eff_lim;
    logic [PL_W-1:0]  rpl;
    logic [PL_W-1:0]  eff_pl;

    always_comb begin
        rpl = sel[PL_W-1:0];
        glb = sel[PL_W];
        idx = sel[SEG_W-1:PL_W+1];

        eff_off = big ? off : {{(OFF_W-HALF_W){1'b0}}, off[HALF_W-1:0]};

        lim_ext = OFF_W'(limit);
        eff_lim = gran ? ((lim_ext << GRAN_SH) | GRAN_MASK) : lim_ext;

        eff_pl = (rpl > cpl) ? rpl : cpl;

        if (!present) begin
            fault = FLT_ABSENT;
        end else if (eff_pl > dpl) begin
            fault = FLT_PRIV;
        end else if (eff_off > eff_lim) begin
            fault = FLT_LIMIT;
        end else begin
            fault = FLT_NONE;
        end

        addr = (fault == FLT_NONE) ? (base + eff_off) : '0;
    end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  fault_e            in_fault,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic              in_glb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_fault,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_glb
);
    ostate_e state_q;
    ostate_e state_d;
    logic    load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: load, drain, stall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (load) state_d = ST_FULL;
            ST_FULL:  if (!load && out_ready) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // handshake outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        load = in_valid && in_ready;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_fault <= 2'd0;
            out_idx   <= '0;
            out_glb   <= 1'b0;
        end else if (load) begin
            out_addr  <= in_addr;
            out_fault <= in_fault;
            out_idx   <= in_idx;
            out_glb   <= in_glb;
        end
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    parameter int REAL_W  = 20,
    parameter int PL_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_prot,
    input  logic [SEG_W-1:0]        req_seg,
    input  logic [OFF_W-1:0]        req_off,
    input  logic [PL_W-1:0]         req_cpl,
    input  logic [OFF_W-1:0]        desc_base,
    input  logic [LIM_W-1:0]        desc_limit,
    input  logic                    desc_gran,
    input  logic                    desc_present,
    input  logic                    desc_big,
    input  logic [PL_W-1:0]         desc_dpl,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [OFF_W-1:0]        rsp_addr,
    output logic [1:0]              rsp_fault,
    output logic [SEG_W-PL_W-2:0]   rsp_index,
    output logic                    rsp_global
);
    localparam int IDX_W = SEG_W - PL_W - 1;

    logic [OFF_W-1:0] real_addr;
    logic [OFF_W-1:0] prot_addr;
    fault_e           prot_fault;
    logic [IDX_W-1:0] prot_idx;
    logic             prot_glb;

    logic [OFF_W-1:0] sel_addr;
    fault_e           sel_fault;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_glb;

    seg_real_path #(
        .SEG_W (SEG_W),
        .REAL_W(REAL_W),
        .OFF_W (OFF_W)
    ) real_i (
        .seg (req_seg),
        .off (req_off),
        .addr(real_addr)
    );

    seg_prot_path #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .LIM_W  (LIM_W),
        .GRAN_SH(GRAN_SH),
        .PL_W   (PL_W)
    ) prot_i (
        .sel    (req_seg),
        .off    (req_off),
        .cpl    (req_cpl),
        .base   (desc_base),
        .limit  (desc_limit),
        .gran   (desc_gran),
        .present(desc_present),
        .big    (desc_big),
        .dpl    (desc_dpl),
        .addr   (prot_addr),
        .fault  (prot_fault),
        .idx    (prot_idx),
        .glb    (prot_glb)
    );

    always_comb begin
        if (req_prot) begin
            sel_addr  = prot_addr;
            sel_fault = prot_fault;
            sel_idx   = prot_idx;
            sel_glb   = prot_glb;
        end else begin
            sel_addr  = real_addr;
            sel_fault = FLT_NONE;
            sel_idx   = '0;
            sel_glb   = 1'b0;
        end
    end

    seg_out_stage #(
        .ADDR_W(OFF_W),
        .IDX_W (IDX_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_addr  (sel_addr),
        .in_fault (sel_fault),
        .in_idx   (sel_idx),
        .in_glb   (sel_glb),
        .out_valid(rsp_valid),
        .out_ready(rsp_ready),
        .out_addr (rsp_addr),
        .out_fault(rsp_fault),
        .out_idx  (rsp_index),
        .out_glb  (rsp_global)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int OFF_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_prot,
    input logic             desc_present,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [OFF_W-1:0] rsp_addr,
    input logic [1:0]       rsp_fault
);
    // R9
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

    // R10
    ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R1
    real_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_prot |=> rsp_fault == 2'd0);

    // R6
    absent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_prot && !desc_present |=> rsp_fault == 2'd1);

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_addr == '0);
endmodule

bind seg_xlate_top seg_xlate_chk #(.OFF_W(OFF_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_prot    (req_prot),
    .desc_present(desc_present),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_addr    (rsp_addr),
    .rsp_fault   (rsp_fault)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;

    typedef struct packed {
        logic        prot;
        logic [15:0] seg;
        logic [31:0] off;
        logic [1:0]  cpl;
        logic [31:0] base;
        logic [19:0] limit;
        logic        gran;
        logic        present;
        logic        big;
        logic [1:0]  dpl;
        logic [31:0] e_addr;
        logic [1:0]  e_fault;
        logic [12:0] e_idx;
        logic        e_glb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        // R1 basic real mode
        '{1'b0, 16'h1100, 32'h0000_0450, 2'd0, 32'hDEAD_BEEF, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0,
          32'h0001_1450, 2'd0, 13'd0, 1'b0, 4'd1},
        // R1 wrap modulo 2^20, upper offset ignored
        '{1'b0, 16'hFFFF, 32'hABCD_0020, 2'd3, 32'h0, 20'h0, 1'b0, 1'b0, 1'b0, 2'd0,
          32'h0000_0010, 2'd0, 13'd0, 1'b0, 4'd1},
        // R2 base plus offset, R12 idx 1 local
        '{1'b1, 16'h000B, 32'h0000_1234, 2'd0, 32'h0010_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 2'd3,
          32'h0010_1234, 2'd0, 13'd1, 1'b0, 4'd2},
        // R2 wrap modulo 2^32, R12 idx 2 global
        '{1'b1, 16'h0014, 32'h0000_2000, 2'd0, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 2'd0,
          32'h0000_1000, 2'd0, 13'd2, 1'b1, 4'd2},
        // R3 16-bit default truncates offset
        '{1'b1, 16'h0010, 32'h1234_5678, 2'd0, 32'h0002_0000, 20'hFFFFF, 1'b0, 1'b1, 1'b0, 2'd0,
          32'h0002_5678, 2'd0, 13'd2, 1'b0, 4'd3},
        // R4 offset equal to byte limit
        '{1'b1, 16'h0008, 32'h0000_0FFF, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 2'd0,
          32'h0000_1FFF, 2'd0, 13'd1, 1'b0, 4'd4},
        // R4 one above byte limit
        '{1'b1, 16'h0008, 32'h0000_1000, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 2'd0,
          32'h0000_0000, 2'd3, 13'd1, 1'b0, 4'd4},
        // R5 page granularity top byte
        '{1'b1, 16'h0008, 32'h0000_3FFF, 2'd0, 32'h0000_0000, 20'h00003, 1'b1, 1'b1, 1'b1, 2'd0,
          32'h0000_3FFF, 2'd0, 13'd1, 1'b0, 4'd5},
        // R5 page granularity one above
        '{1'b1, 16'h0008, 32'h0000_4000, 2'd0, 32'h0000_0000, 20'h00003, 1'b1, 1'b1, 1'b1, 2'd0,
          32'h0000_0000, 2'd3, 13'd1, 1'b0, 4'd5},
        // R6 absent wins over privilege and limit
        '{1'b1, 16'h001F, 32'hFFFF_FFFF, 2'd3, 32'h0000_0000, 20'h00000, 1'b0, 1'b0, 1'b1, 2'd0,
          32'h0000_0000, 2'd1, 13'd3, 1'b1, 4'd6},
        // R7 current level too weak, wins over limit
        '{1'b1, 16'h0018, 32'h0000_0100, 2'd2, 32'h0000_0000, 20'h00010, 1'b0, 1'b1, 1'b1, 2'd1,
          32'h0000_0000, 2'd2, 13'd3, 1'b0, 4'd7},
        // R7 requestor level too weak
        '{1'b1, 16'h0002, 32'h0000_0010, 2'd0, 32'h0000_0000, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 2'd1,
          32'h0000_0000, 2'd2, 13'd0, 1'b0, 4'd7},
        // R7 equal levels pass
        '{1'b1, 16'h0005, 32'h0000_0010, 2'd1, 32'h0000_0100, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 2'd1,
          32'h0000_0110, 2'd0, 13'd0, 1'b1, 4'd7},
        // R3 truncated offset also used for limit test
        '{1'b1, 16'h0000, 32'hFFFF_0000, 2'd0, 32'h0000_0005, 20'h00000, 1'b0, 1'b1, 1'b0, 2'd0,
          32'h0000_0005, 2'd0, 13'd0, 1'b0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_prot = 1'b0;
    logic [15:0] req_seg = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_cpl = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        desc_present = 1'b0;
    logic        desc_big = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic [12:0] rsp_index;
    logic        rsp_global;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_prot(req_prot),
        .req_seg(req_seg), .req_off(req_off), .req_cpl(req_cpl),
        .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
        .desc_present(desc_present), .desc_big(desc_big), .desc_dpl(desc_dpl),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_index(rsp_index), .rsp_global(rsp_global)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req_prot     = v.prot;
        req_seg      = v.seg;
        req_off      = v.off;
        req_cpl      = v.cpl;
        desc_base    = v.base;
        desc_limit   = v.limit;
        desc_gran    = v.gran;
        desc_present = v.present;
        desc_big     = v.big;
        desc_dpl     = v.dpl;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        string tag;
        // R11 during reset
        repeat (3) @(negedge clk);
        check("R11", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R11", "req_ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R11", "req_ready after reset", 32'(req_ready), 32'd1);

        // vector table: one result per request, due one edge after acceptance (R9)
        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            req_valid = 1'b1;
            rsp_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            tag = $sformatf("R%0d vec%0d", VT[i].req, i);
            check(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
            check(tag, "rsp_addr", rsp_addr, VT[i].e_addr);
            check(tag, "rsp_fault", 32'(rsp_fault), 32'(VT[i].e_fault));
            // R12 selector echo
            check(tag, "rsp_index R12", 32'(rsp_index), 32'(VT[i].e_idx));
            check(tag, "rsp_global R12", 32'(rsp_global), 32'(VT[i].e_glb));
        end
        @(negedge clk);
        check("R9", "drained", 32'(rsp_valid), 32'd0);

        // stall: R9 hold and R10 blocking
        apply(VT[0]);
        req_valid = 1'b1;
        rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9", "valid after accept", 32'(rsp_valid), 32'd1);
        check("R10", "ready low while full", 32'(req_ready), 32'd0);
        apply(VT[2]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", "held valid", 32'(rsp_valid), 32'd1);
            check("R9", "held addr", rsp_addr, 32'h0001_1450);
            check("R10", "still blocked", 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        #0.5;
        check("R10", "ready follows rsp_ready", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "replaced valid", 32'(rsp_valid), 32'd1);
        check("R9", "replaced addr", rsp_addr, 32'h0010_1234);
        check("R12", "replaced index", 32'(rsp_index), 32'd1);
        @(negedge clk);
        check("R9", "empty after drain", 32'(rsp_valid), 32'd0);

        // R1: descriptor inputs have no effect in real mode
        apply(VT[0]);
        desc_present = 1'b0;
        desc_dpl = 2'd0;
        req_cpl = 2'd3;
        desc_base = 32'hFFFF_FFFF;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "real addr ignores descriptor", rsp_addr, 32'h0001_1450);
        check("R1", "real fault ignores descriptor", 32'(rsp_fault), 32'd0);
        @(negedge clk);

        // R11: reset mid-stall clears the output
        apply(VT[0]);
        req_valid = 1'b1;
        rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "valid cleared by reset", 32'(rsp_valid), 32'd0);
        check("R11", "ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        rsp_ready = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule